// File: doc/BRIEF.md
# Shutter Configuration Serial Port

The block takes a 19-bit configuration word over three serial wires: a shift clock, a data line and a strobe. The three inputs come in asynchronously. Each one goes through a two-flop synchronizer into the system clock domain, and a rising edge of the synchronized signal counts as one event. On each shift event one data bit enters a shift register. On a strobe event the whole word is copied into a holding register.

The four 2-bit phase fields take effect one clock after the holding register loads. The shutter fields wait for the frame timing instead. The shutter mode moves to its active register on the first line start, seen as a rising edge of `h_ref`, during which the readout pulse `rd_active` is high. The shutter speed moves to its active register on the next such line. Because of this, a shutter change never lands in the middle of a frame. A new word that arrives before both steps finish replaces the held data, and the sequence starts again from the mode step.

Top module: `shutter_cfg_port`

## Requirements
- R1: Each rising edge of the synchronized `ser_clk` shifts in one bit from `ser_dat`. The first bit sent is bit D00 of the word and the last is D18. Holding `ser_clk` high produces only one shift.
- R2: A rising edge of the synchronized `ser_stb` captures the word. The four phase outputs follow the captured word within a few clocks, with no line event needed.
- R3: The word layout has the lower bit index as the LSB of each field. Shutter speed is D00–D08. Shutter mode is D09–D10. `ph_reset` is D11–D12, `ph_clamp` is D13–D14, `ph_hold` is D15–D16 and `ph_feed` is D17–D18.
- R4: After a capture, `shutter_mode` takes the new value at the first rising edge of `h_ref` during which `rd_active` is high. `shutter_speed` does not change at that edge.
- R5: `shutter_speed` takes the new value at the next rising edge of `h_ref` with `rd_active` high, and never in the same cycle as a mode change.
- R6: A rising edge of `h_ref` while `rd_active` is low has no effect on `shutter_mode` or `shutter_speed`.
- R7: A capture that arrives before the speed step overwrites the held data and restarts the sequence at the mode step.
- R8: Once both steps are done, further qualified line edges change nothing until the next capture.
- R9: After reset, `shutter_speed`, `shutter_mode` (0 means shutter off) and all phase outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_stb | input | 1 | Serial strobe, asynchronous |
| h_ref | input | 1 | Horizontal line reference; a rising edge starts a line |
| rd_active | input | 1 | Readout pulse active during the current line |
| shutter_speed | output | 9 | Active shutter speed |
| shutter_mode | output | 2 | Active shutter mode |
| ph_reset | output | 2 | Phase select for the reset pulse |
| ph_clamp | output | 2 | Phase select for the clamp pulse |
| ph_hold | output | 2 | Phase select for the sample-hold pulse |
| ph_feed | output | 2 | Phase select for the feed-through sampling pulse |

## Verification
The bench checks that a qualified line commits only the mode and leaves the speed at its old value. A design that commits both fields on one line fails that check. It sends lines with the readout pulse low, which catch any design that commits on every line. It sends a second word between the mode step and the speed step. A design that keeps the old step state would then commit the new word's speed too early, or mix the speed of one word with the mode of another. Finally, two words with asymmetric field values catch any swapped field or reversed bit order in the phase and speed outputs.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;
  localparam int SPD_W  = 9;
  localparam int MODE_W = 2;
  localparam int PH_W   = 2;
  localparam int WORD_W = SPD_W + MODE_W + 4 * PH_W;

  // Packed from MSB to LSB, so spd occupies the lowest word bits.
  typedef struct packed {
    logic [PH_W-1:0]   feed;
    logic [PH_W-1:0]   hold;
    logic [PH_W-1:0]   clamp;
    logic [PH_W-1:0]   rst;
    logic [MODE_W-1:0] mode;
    logic [SPD_W-1:0]  spd;
  } cfg_word_t;

  // First bit sent ends up in bit 0 after WORD_W shifts.
  function automatic logic [WORD_W-1:0] shift_in(input logic [WORD_W-1:0] sr,
                                                 input logic b);
    return {b, sr[WORD_W-1:1]};
  endfunction

  function automatic cfg_word_t to_fields(input logic [WORD_W-1:0] w);
    return cfg_word_t'(w);
  endfunction
endpackage

// File: rtl/shcfg_sync_edge.sv
module shcfg_sync_edge #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level,
  output logic rise
);
  logic [STAGES:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= {(STAGES+1){RST_VAL}};
    else        q <= {q[STAGES-1:0], async_in};
  end

  assign level = q[STAGES-1];
  assign rise  = q[STAGES-1] & ~q[STAGES];
endmodule

// File: rtl/shcfg_shift_hold.sv
module shcfg_shift_hold
  import shcfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      shift_en,
  input  logic      bit_in,
  input  logic      capture,
  output cfg_word_t held
);
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr   <= '0;
      held <= '0;
    end else begin
      if (shift_en) sr <= shift_in(sr, bit_in);
      if (capture)  held <= to_fields(sr);
    end
  end
endmodule

// File: rtl/shcfg_commit_ctrl.sv
module shcfg_commit_ctrl
  import shcfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              new_word,
  input  logic              line_evt,
  input  logic              rd_active,
  input  logic [SPD_W-1:0]  held_spd,
  input  logic [MODE_W-1:0] held_mode,
  output logic [SPD_W-1:0]  spd_act,
  output logic [MODE_W-1:0] mode_act,
  output logic              pend,
  output logic              step
);
  logic qual_line;
  assign qual_line = line_evt & rd_active & pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spd_act  <= '0;
      mode_act <= '0;
      pend     <= 1'b0;
      step     <= 1'b0;
    end else if (new_word) begin
      pend <= 1'b1;
      step <= 1'b0;
    end else if (qual_line) begin
      if (!step) begin
        mode_act <= held_mode;
        step     <= 1'b1;
      end else begin
        spd_act <= held_spd;
        step    <= 1'b0;
        pend    <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/shutter_cfg_port.sv
module shutter_cfg_port
  import shcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_stb,
  input  logic              h_ref,
  input  logic              rd_active,
  output logic [SPD_W-1:0]  shutter_speed,
  output logic [MODE_W-1:0] shutter_mode,
  output logic [PH_W-1:0]   ph_reset,
  output logic [PH_W-1:0]   ph_clamp,
  output logic [PH_W-1:0]   ph_hold,
  output logic [PH_W-1:0]   ph_feed
);
  localparam int N_SER = 3;

  logic [N_SER-1:0] ser_raw, ser_lvl, ser_rise;
  assign ser_raw = {ser_stb, ser_dat, ser_clk};

  for (genvar i = 0; i < N_SER; i++) begin : g_sync
    shcfg_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_in(ser_raw[i]),
      .level   (ser_lvl[i]),
      .rise    (ser_rise[i])
    );
  end

  // Named events for the checker
  logic shift_evt, stb_evt, line_evt, h_ref_q, stb_d;
  logic pend_q, commit_step;
  cfg_word_t held;

  assign shift_evt = ser_rise[0];
  assign stb_evt   = ser_rise[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_ref_q <= 1'b0;
    else        h_ref_q <= h_ref;
  end
  assign line_evt = h_ref & ~h_ref_q;

  shcfg_shift_hold u_sh (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(shift_evt),
    .bit_in  (ser_lvl[1]),
    .capture (stb_evt),
    .held    (held)
  );

  shcfg_commit_ctrl u_cc (
    .clk      (clk),
    .rst_n    (rst_n),
    .new_word (stb_evt),
    .line_evt (line_evt),
    .rd_active(rd_active),
    .held_spd (held.spd),
    .held_mode(held.mode),
    .spd_act  (shutter_speed),
    .mode_act (shutter_mode),
    .pend     (pend_q),
    .step     (commit_step)
  );

  // Phase fields follow the held word one clock after it loads
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_d    <= 1'b0;
      ph_reset <= '0;
      ph_clamp <= '0;
      ph_hold  <= '0;
      ph_feed  <= '0;
    end else begin
      stb_d <= stb_evt;
      if (stb_d) begin
        ph_reset <= held.rst;
        ph_clamp <= held.clamp;
        ph_hold  <= held.hold;
        ph_feed  <= held.feed;
      end
    end
  end
endmodule

// File: rtl/shcfg_checker.sv
module shcfg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       line_evt,
  input logic       rd_active,
  input logic       stb_evt,
  input logic       pend_q,
  input logic       commit_step,
  input logic [8:0] spd,
  input logic [1:0] mode,
  input logic [7:0] ph_bus
);
  p_mode_on_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $past(line_evt && rd_active));

  p_spd_second_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(spd) |-> $past(line_evt && rd_active && commit_step));

  p_not_together_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode) |-> $stable(spd));

  p_rd_low_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (line_evt && !rd_active) |=> ($stable(mode) && $stable(spd)));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stb_evt |=> (pend_q && !commit_step));

  p_idle_no_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> ($stable(mode) && $stable(spd)));

  p_phase_after_stb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ph_bus) |-> $past(stb_evt, 2));
endmodule

bind shutter_cfg_port shcfg_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .line_evt   (line_evt),
  .rd_active  (rd_active),
  .stb_evt    (stb_evt),
  .pend_q     (pend_q),
  .commit_step(commit_step),
  .spd        (shutter_speed),
  .mode       (shutter_mode),
  .ph_bus     ({ph_feed, ph_hold, ph_clamp, ph_reset})
);

// File: tb/shutter_cfg_port_bench.sv
module shutter_cfg_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_stb = 1'b0;
  logic h_ref = 1'b0, rd_active = 1'b0;
  logic [8:0] shutter_speed;
  logic [1:0] shutter_mode, ph_reset, ph_clamp, ph_hold, ph_feed;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  shutter_cfg_port u_shutter_cfg_port (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_stb(ser_stb), .h_ref(h_ref), .rd_active(rd_active),
    .shutter_speed(shutter_speed), .shutter_mode(shutter_mode),
    .ph_reset(ph_reset), .ph_clamp(ph_clamp), .ph_hold(ph_hold), .ph_feed(ph_feed)
  );

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Word layout as the requirements state it (R3)
  function automatic logic [18:0] mk(input logic [8:0] s, input logic [1:0] m,
      input logic [1:0] pr, input logic [1:0] pc, input logic [1:0] ph, input logic [1:0] pf);
    logic [18:0] w;
    w[8:0] = s; w[10:9] = m; w[12:11] = pr; w[14:13] = pc; w[16:15] = ph; w[18:17] = pf;
    return w;
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: D00 first, one rising edge per bit
  task automatic send_word(input logic [18:0] w);
    for (int i = 0; i < 19; i++) begin
      ser_dat = w[i]; wait_clk(4);
      ser_clk = 1'b1; wait_clk(5);
      ser_clk = 1'b0; wait_clk(4);
    end
    ser_stb = 1'b1; wait_clk(5);
    ser_stb = 1'b0; wait_clk(6);
  endtask

  task automatic line(input logic rd);
    rd_active = rd; h_ref = 1'b1; wait_clk(3);
    h_ref = 1'b0; wait_clk(3);
    rd_active = 1'b0; wait_clk(1);
  endtask

  task automatic chk_phases(input string tag, input logic [18:0] w);
    chk({tag, " ph_reset"}, 9'(ph_reset), 9'(w[12:11]));
    chk({tag, " ph_clamp"}, 9'(ph_clamp), 9'(w[14:13]));
    chk({tag, " ph_hold"},  9'(ph_hold),  9'(w[16:15]));
    chk({tag, " ph_feed"},  9'(ph_feed),  9'(w[18:17]));
  endtask

  task automatic t_reset;
    chk("R9 speed", shutter_speed, 9'h0);
    chk("R9 mode", 9'(shutter_mode), 9'h0);
    chk_phases("R9", 19'h0);
  endtask

  task automatic t_basic(input logic [18:0] w, input logic [18:0] prev);
    send_word(w);
    chk_phases("R2 R3", w);
    chk("R4 mode held before line", 9'(shutter_mode), 9'(prev[10:9]));
    line(1'b0);
    chk("R6 mode unchanged", 9'(shutter_mode), 9'(prev[10:9]));
    chk("R6 speed unchanged", shutter_speed, prev[8:0]);
    line(1'b1);
    chk("R4 mode committed", 9'(shutter_mode), 9'(w[10:9]));
    chk("R4 speed not yet", shutter_speed, prev[8:0]);
    line(1'b0);
    chk("R6 speed waits", shutter_speed, prev[8:0]);
    line(1'b1);
    chk("R5 speed committed", shutter_speed, w[8:0]);
    chk("R5 mode kept", 9'(shutter_mode), 9'(w[10:9]));
  endtask

  task automatic t_idle(input logic [18:0] w);
    line(1'b1); line(1'b1);
    chk("R8 speed stays", shutter_speed, w[8:0]);
    chk("R8 mode stays", 9'(shutter_mode), 9'(w[10:9]));
  endtask

  task automatic t_restart(input logic [18:0] old, input logic [18:0] b, input logic [18:0] c);
    send_word(b);
    line(1'b1);
    chk("R7 first mode", 9'(shutter_mode), 9'(b[10:9]));
    send_word(c);
    chk_phases("R7 R3", c);
    line(1'b1);
    chk("R7 restart mode", 9'(shutter_mode), 9'(c[10:9]));
    chk("R7 speed not early", shutter_speed, old[8:0]);
    line(1'b1);
    chk("R7 speed final", shutter_speed, c[8:0]);
  endtask

  initial begin
    logic [18:0] wa, wb, wc;
    wa = mk(9'h1A5, 2'd2, 2'd1, 2'd2, 2'd3, 2'd0);
    wb = mk(9'h0F3, 2'd1, 2'd3, 2'd0, 2'd1, 2'd2);
    wc = mk(9'h155, 2'd3, 2'd2, 2'd3, 2'd0, 2'd1);
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_basic(wa, 19'h0);
    t_idle(wa);
    t_restart(wa, wb, wc);
    t_basic(wa, wc);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule